// File: doc/BRIEF.md
# Programmable Periodic Software Trigger Generator

This block produces an endless train of one-cycle trigger pulses at a rate that software chooses. Software writes a 16-bit command word with a valid strobe. The block accepts the word only when its upper byte carries the rate opcode. It then takes the lower byte as an 8-bit period setting. The period is an affine function of that setting: a base of 25 ms plus 12.5 ms for each step. A setting of 0 gives 40 Hz, and a setting of 255 gives a period of about 3.21 s (near 0.3 Hz). Both the step and the base are derived, as cycle counts, from the clock-frequency parameter.

Generation runs only while `enable` is high. Once the block is configured, it keeps firing without further commands. A new setting written while the generator runs waits for the end of the period in progress, so that period is never cut short. While `enable` is low, a new setting is taken at once. A parameter selects how the period is counted: one wide counter compared against a computed period, or a step prescaler feeding a step counter. Both choices give the same timing.

Top module: `soft_trig_gen`

## Requirements
- R1: While `rst` is high, `trig_pulse` is 0. After reset the active setting is 0, so the first period after enabling lasts 2*STEP cycles.
- R2: A command is accepted only on a cycle where `cmd_valid` is 1 and `cmd_word[15:8]` equals the opcode (default 8'h21). Its `cmd_word[7:0]` becomes the new setting. The opcode byte has no effect while `cmd_valid` is 0.
- R3: With setting S, the period is (2 + S) * STEP clock cycles, where STEP = CLK_FREQ_HZ / 80 (12.5 ms). Setting 0 therefore gives 25 ms.
- R4: While enabled, pulses repeat at every period with no further commands. Each pulse is exactly one clock cycle wide.
- R5: Counting starts at zero on the first rising edge at which `enable` is sampled high. The first pulse is visible after the P-th such edge, where P is the period.
- R6: A setting accepted while enabled leaves the period in progress at its old length. The next period uses the new length.
- R7: A valid command whose upper byte differs from the opcode is ignored, and the pulse period stays unchanged.
- R8: While `enable` is low, no pulses appear and the period counter is cleared. When `enable` is raised again, a full period runs before the next pulse.
- R9: A setting accepted while `enable` is low applies to the first period after enabling. When several settings arrive within one period, the last one wins.
- R10: The flat-counter and cascaded-counter variants produce identical pulse trains for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generation gate; low clears the period counter |
| cmd_valid | input | 1 | Qualifies `cmd_word` for one cycle |
| cmd_word | input | 16 | Opcode in bits 15:8, period setting in bits 7:0 |
| trig_pulse | output | 1 | One-cycle trigger pulse at the end of each period |

## Verification
The bench builds the block with CLK_FREQ_HZ = 320. This gives a step of 4 cycles and a base of 8 cycles, so the longest period, at setting 255, is 1028 cycles. At that size, every third setting from 0 up to 255 can be swept, and each first-pulse latency is checked against (2 + S) * 4. A second instance uses the cascaded counter and is compared with the flat one on every cycle. Further checks time changes made in the middle of a period, foreign opcodes, back-to-back commands within one period, a gap in `enable`, and a reset while the generator runs.

// File: rtl/stg_pkg.sv
package stg_pkg;

   typedef enum int {
      STG_FLAT    = 0,
      STG_CASCADE = 1
   } stg_count_e;

   // cycles in one 12.5 ms step (1/80 s)
   function automatic int step_cycles(input int clk_hz);
      return clk_hz / 80;
   endfunction

   // counter width able to hold n distinct values (at least 1)
   function automatic int width_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/stg_cmd_decode.sv
module stg_cmd_decode #(
   parameter int          OP_W   = 8,
   parameter int          SET_W  = 8,
   parameter logic [7:0]  OPCODE = 8'h21,
   localparam int         CMD_W  = OP_W + SET_W
) (
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   output logic             upd_valid,
   output logic [SET_W-1:0] upd_set
);

   logic [OP_W-1:0] op_field;

   always_comb begin
      op_field  = cmd_word[CMD_W-1:SET_W];
      upd_set   = cmd_word[SET_W-1:0];
      upd_valid = cmd_valid && (op_field == OP_W'(OPCODE));
   end

endmodule

// File: rtl/stg_rate_hold.sv
module stg_rate_hold #(
   parameter int SET_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             running,
   input  logic             boundary,
   input  logic             upd_valid,
   input  logic [SET_W-1:0] upd_set,
   output logic [SET_W-1:0] active_set,
   output logic [SET_W-1:0] pend_set,
   output logic             pend_valid
);

   logic apply_now;

   always_comb apply_now = !running || boundary;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_set <= '0;
         pend_set   <= '0;
         pend_valid <= 1'b0;
      end else if (apply_now) begin
         if (upd_valid) begin
            active_set <= upd_set;
            pend_set   <= upd_set;
         end else if (pend_valid) begin
            active_set <= pend_set;
         end
         pend_valid <= 1'b0;
      end else if (upd_valid) begin
         pend_set   <= upd_set;
         pend_valid <= 1'b1;
      end
   end

   AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
      (running && !boundary) |=> $stable(active_set)); // R6

endmodule

// File: rtl/stg_period_timer.sv
module stg_period_timer
   import stg_pkg::*;
#(
   parameter int         SET_W       = 8,
   parameter int         STEP_CYC    = 625000,
   parameter int         BASE_STEPS  = 2,
   parameter stg_count_e COUNT_STYLE = STG_FLAT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic [SET_W-1:0] active_set,
   output logic             boundary,
   output logic             trig
);

   localparam int MAX_STEPS = BASE_STEPS + (1 << SET_W) - 1;
   localparam int MAX_CYC   = MAX_STEPS * STEP_CYC;

   logic term;

   generate
      if (COUNT_STYLE == STG_FLAT) begin : g_flat
         localparam int CNT_W = width_for(MAX_CYC);
         logic [CNT_W-1:0] cnt;
         logic [CNT_W-1:0] period_m1;

         always_comb begin
            period_m1 = CNT_W'((32'(active_set) + 32'(BASE_STEPS))
                               * 32'(STEP_CYC) - 32'd1);
            term      = (cnt == period_m1);
         end

         always_ff @(posedge clk) begin
            if (rst || !enable || term) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
         end

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
            enable |-> (cnt <= period_m1)); // R3
      end else begin : g_cascade
         localparam int PRE_W = width_for(STEP_CYC);
         localparam int SC_W  = width_for(MAX_STEPS);
         logic [PRE_W-1:0] pre;
         logic [SC_W-1:0]  sc;
         logic [SC_W-1:0]  steps_m1;
         logic             pre_wrap;

         always_comb begin
            steps_m1 = SC_W'(32'(active_set) + 32'(BASE_STEPS) - 32'd1);
            pre_wrap = (pre == PRE_W'(STEP_CYC - 1));
            term     = pre_wrap && (sc == steps_m1);
         end

         always_ff @(posedge clk) begin
            if (rst || !enable || pre_wrap) pre <= '0;
            else                            pre <= pre + 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst || !enable || term) sc <= '0;
            else if (pre_wrap)          sc <= sc + 1'b1;
         end

         AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
            enable |-> (sc <= steps_m1)); // R3
      end
   endgenerate

   always_comb boundary = enable && term;

   always_ff @(posedge clk) begin
      if (rst) trig <= 1'b0;
      else     trig <= boundary;
   end

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      trig |=> !trig); // R4

endmodule

// File: rtl/soft_trig_gen.sv
module soft_trig_gen
   import stg_pkg::*;
#(
   parameter int          CLK_FREQ_HZ = 50_000_000,
   parameter int          OP_W        = 8,
   parameter int          SET_W       = 8,
   parameter logic [7:0]  OPCODE      = 8'h21,
   parameter int          BASE_STEPS  = 2,
   parameter stg_count_e  COUNT_STYLE = STG_FLAT
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        enable,
   input  logic        cmd_valid,
   input  logic [15:0] cmd_word,
   output logic        trig_pulse
);

   localparam int CMD_W    = OP_W + SET_W;
   localparam int STEP_CYC = step_cycles(CLK_FREQ_HZ);

   generate
      if (CMD_W != 16) begin : g_bad_cmd
         $error("soft_trig_gen: opcode plus setting must span 16 bits");
      end
      if (CLK_FREQ_HZ % 80 != 0 || STEP_CYC < 1) begin : g_bad_clk
         $error("soft_trig_gen: clock must be a positive multiple of 80 Hz");
      end
      if (BASE_STEPS < 1 || BASE_STEPS * STEP_CYC < 2) begin : g_bad_base
         $error("soft_trig_gen: shortest period must be at least 2 cycles");
      end
   endgenerate

   logic             upd_valid;
   logic [SET_W-1:0] upd_set;
   logic [SET_W-1:0] active_set;
   logic [SET_W-1:0] pend_set;
   logic             pend_valid;
   logic             boundary;

   stg_cmd_decode #(
      .OP_W   (OP_W),
      .SET_W  (SET_W),
      .OPCODE (OPCODE)
   ) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .upd_valid (upd_valid),
      .upd_set   (upd_set)
   );

   stg_rate_hold #(
      .SET_W (SET_W)
   ) u_hold (
      .clk        (clk),
      .rst        (rst),
      .running    (enable),
      .boundary   (boundary),
      .upd_valid  (upd_valid),
      .upd_set    (upd_set),
      .active_set (active_set),
      .pend_set   (pend_set),
      .pend_valid (pend_valid)
   );

   stg_period_timer #(
      .SET_W       (SET_W),
      .STEP_CYC    (STEP_CYC),
      .BASE_STEPS  (BASE_STEPS),
      .COUNT_STYLE (COUNT_STYLE)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .enable     (enable),
      .active_set (active_set),
      .boundary   (boundary),
      .trig       (trig_pulse)
   );

   AST_FOREIGN_OP_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_word[CMD_W-1:SET_W] != OP_W'(OPCODE) && !pend_valid)
      |=> $stable(pend_set)); // R7

   AST_NO_TRIG_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      !enable |=> !trig_pulse); // R8

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!trig_pulse && active_set == '0)); // R1

endmodule

// File: tb/soft_trig_gen_test.sv
module soft_trig_gen_test;
   import stg_pkg::*;

   localparam int CLK_HZ = 320;
   localparam int STEP   = CLK_HZ / 80;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enable = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = 16'h0;
   logic        trig_a;
   logic        trig_b;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int last_pulse = 0;
   int interval = 0;
   int pulse_cnt = 0;
   int mism = 0;
   int dbl = 0;
   logic prev_trig = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   soft_trig_gen #(.CLK_FREQ_HZ(CLK_HZ), .COUNT_STYLE(STG_FLAT)) uut (
      .clk(clk), .rst(rst), .enable(enable), .cmd_valid(cmd_valid),
      .cmd_word(cmd_word), .trig_pulse(trig_a));

   soft_trig_gen #(.CLK_FREQ_HZ(CLK_HZ), .COUNT_STYLE(STG_CASCADE)) uut_cascade (
      .clk(clk), .rst(rst), .enable(enable), .cmd_valid(cmd_valid),
      .cmd_word(cmd_word), .trig_pulse(trig_b));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst) begin
         if (trig_a !== trig_b) mism++;
         if (trig_a && prev_trig) dbl++;
         if (trig_a) begin
            interval   = cyc - last_pulse;
            last_pulse = cyc;
            pulse_cnt++;
         end
      end
      prev_trig = trig_a;
   end

   function automatic int per(input int s);
      return (2 + s) * STEP;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [15:0] w);
      cmd_word  = w;
      cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
   endtask

   task automatic wait_pulse(input string req);
      int start;
      int t;
      start = pulse_cnt;
      t = 0;
      while (pulse_cnt == start && t < 3000) begin
         tick();
         t++;
      end
      if (pulse_cnt == start) chk(1'b0, req, t, -1);
   endtask

   // enable from a known cycle and return the latency to the first pulse
   task automatic enable_and_measure(output int lat, input string req);
      int c0;
      enable = 1'b1;
      c0 = cyc;
      wait_pulse(req);
      lat = last_pulse - c0;
   endtask

   initial begin
      int lat;
      int n0;
      repeat (5) tick();
      chk(trig_a == 1'b0, "R1 trig low in reset", int'(trig_a), 0);
      rst = 1'b0;
      tick();

      // R1 / R5: default setting 0 -> 8 cycles from enable
      enable_and_measure(lat, "R5 first pulse");
      chk(lat == per(0), "R1 R5 first-pulse latency", lat, per(0));
      wait_pulse("R4 repeat");
      chk(interval == per(0), "R3 R4 interval setting 0", interval, per(0));
      tick();
      chk(trig_a == 1'b0, "R4 pulse one cycle wide", int'(trig_a), 0);

      // R6: change while running, old period completes
      tick();
      send(16'h2105);
      wait_pulse("R6");
      chk(interval == per(0), "R6 period in progress kept", interval, per(0));
      wait_pulse("R6");
      chk(interval == per(5), "R6 R3 new period", interval, per(5));

      // R7 / R2: foreign opcodes and unqualified opcode ignored
      send(16'h2210);
      send(16'h0021);
      cmd_word = 16'h2140;
      repeat (3) tick();
      wait_pulse("R7");
      wait_pulse("R7");
      chk(interval == per(5), "R7 R2 foreign opcode ignored", interval, per(5));

      // R9: last of two commands in one period wins
      send(16'h2101);
      tick();
      send(16'h2103);
      wait_pulse("R9");
      chk(interval == per(5), "R6 R9 old period completes", interval, per(5));
      wait_pulse("R9");
      chk(interval == per(3), "R9 last command wins", interval, per(3));

      // R8: enable gap, no pulses, full restart
      repeat (3) tick();
      enable = 1'b0;
      n0 = pulse_cnt;
      repeat (30) tick();
      chk(pulse_cnt == n0, "R8 no pulses while disabled", pulse_cnt - n0, 0);
      enable_and_measure(lat, "R8 restart");
      chk(lat == per(3), "R8 full period after re-enable", lat, per(3));

      // R9 / R3: sweep of settings loaded while disabled
      for (int s = 0; s <= 255; s += 3) begin
         enable = 1'b0;
         tick();
         send(16'h2100 | 16'(s));
         enable_and_measure(lat, "R3 sweep");
         chk(lat == per(s), $sformatf("R3 R9 sweep setting %0d", s), lat, per(s));
      end
      wait_pulse("R4 long");
      chk(interval == per(255), "R3 R4 setting 255 interval", interval, per(255));

      // R1: reset during run restores setting 0
      repeat (10) tick();
      rst = 1'b1;
      enable = 1'b0;
      repeat (2) tick();
      chk(trig_a == 1'b0, "R1 trig low during reset", int'(trig_a), 0);
      rst = 1'b0;
      tick();
      enable_and_measure(lat, "R1 after reset");
      chk(lat == per(0), "R1 setting 0 after reset", lat, per(0));

      chk(dbl == 0, "R4 no two-cycle pulses", dbl, 0);
      chk(mism == 0, "R10 variants agree", mism, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule